// File: doc/BRIEF.md
# RTC Initialization and Status Controller

This block holds the handshake between software and a real-time-clock core. Software writes an initialization request bit to stop the calendar counters. It then waits for an acknowledge flag before it loads the time, date and prescaler values. Per-resource write-permission flags tell software when the alarm and wakeup settings may be changed. Pending flags track a sub-second shift request and a recalibration request until the slow RTC domain reports that each has been applied.

Two clocks are involved. The bus clock runs the register write port and every status flag. The slow RTC clock runs the counter-stop output and the permission handshake. Done pulses from the RTC domain reach the bus domain through toggle synchronizers, and levels cross through two-flop synchronizers. The calendar, the alarms, the wakeup counter and the shift and calibration arithmetic all live elsewhere. This block only emits their load strobes and reports their progress.

Write addresses: 0 is the control/status word, 1 is shift, 2 is calibration, 3 is time, 4 is date, 5 is prescaler.

Top module: `rtc_init_ctrl`

## Requirements
- R1: A write to address 0 stores wr_data[7] as the INIT request, which reads back on status bit 7. `cnt_stop` rises no earlier than two RTC-clock edges after INIT is set. It falls again, by the same synchronized path, after INIT is cleared.
- R2: The acknowledge flag (status bit 6 and `init_ack`) is 1 only after INIT has crossed to the RTC domain and back. It drops in the cycle after INIT is written to 0. Writes to address 3, 4 or 5 pulse `cal_load` bit 0, 1 or 2 respectively, but only while the acknowledge flag is 1. At any other time these writes produce no pulse.
- R3: The alarm A and alarm B write flags (status bits 0 and 1, also on their own ports) read 1 once their enable input is low. They read 0 while the enable is high or INIT is 1.
- R4: The wakeup write flag (status bit 2, also `wr_ok_wkup`) reads 1 once `wkup_en` is low. It reads 0 while `wkup_en` is high or INIT is 1.
- R5: A write to address 1 pulses `shift_load` and sets the shift-pending flag (status bit 3) in the same edge. The flag clears only after a `shift_done` pulse has crossed over. It stays set when INIT is cleared first. Writing either value to bit 3 at address 0 has no effect on it.
- R6: The shadow-sync flag (status bit 5) is set by a crossed `copy_done` pulse. It is held at 0 while INIT is 1, while a shift is pending, or while `shadow_bypass` is 1. The write that sets INIT or starts a shift clears it in that same edge. An address 0 write with bit 5 = 0 clears it, and bit 5 = 1 has no effect.
- R7: The initialization-status flag (status bit 4) follows the synchronized `year_nonzero` level.
- R8: A write to address 2 while the recalibration-pending flag (status bit 16) is 0 pulses `calib_load` and sets the flag. Writes to address 2 while the flag is 1 produce no `calib_load`. A crossed `calib_done` pulse clears the flag.
- R9: After reset every flag and output is 0. Status bits 8 to 15 and 17 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Bus-domain synchronous active-high reset |
| rtc_clk | input | 1 | Slow RTC clock |
| rtc_rst | input | 1 | RTC-domain synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| alarm_a_en | input | 1 | Alarm A enable (bus domain) |
| alarm_b_en | input | 1 | Alarm B enable (bus domain) |
| wkup_en | input | 1 | Wakeup timer enable (bus domain) |
| shadow_bypass | input | 1 | Shadow registers bypassed |
| year_nonzero | input | 1 | Calendar year differs from 0 (RTC domain) |
| copy_done | input | 1 | Shadow copy finished pulse (RTC domain) |
| shift_done | input | 1 | Shift applied pulse (RTC domain) |
| calib_done | input | 1 | Calibration applied pulse (RTC domain) |
| status | output | 32 | Status word |
| init_ack | output | 1 | Initialization acknowledged |
| cnt_stop | output | 1 | Counter stop (RTC domain) |
| wr_ok_alarm_a | output | 1 | Alarm A may be written |
| wr_ok_alarm_b | output | 1 | Alarm B may be written |
| wr_ok_wkup | output | 1 | Wakeup timer may be written |
| cal_load | output | 3 | Accepted time/date/prescaler write strobes |
| calib_load | output | 1 | Accepted calibration write strobe |
| shift_load | output | 1 | Shift write strobe |

## Verification
The shadow-sync flag and the shift-pending or INIT bit can change in the same bus edge. A shift write, or a control write that sets INIT, arrives while the shadow-sync flag is 1. The bench creates this by first setting the flag with a crossed copy-done pulse, then issuing that write. It checks the status word at the very next sample: the new pending or INIT bit must read 1 and the shadow-sync flag must already read 0, with no cycle in which both read 1. A sweep over every combination of INIT, pending shift and bypass also checks that a copy-done pulse arriving under any hold condition leaves the flag at 0.

// File: rtl/rtc_init_pkg.sv
package rtc_init_pkg;

    localparam int STATUS_W  = 32;
    localparam int B_WF_A    = 0;
    localparam int B_WF_B    = 1;
    localparam int B_WF_WKUP = 2;
    localparam int B_SHIFT   = 3;
    localparam int B_INITS   = 4;
    localparam int B_SYNC    = 5;
    localparam int B_ACK     = 6;
    localparam int B_INIT    = 7;
    localparam int B_RECAL   = 16;

    // permission vector carried across domains
    localparam int PERM_W    = 4;
    localparam int P_WF_A    = 0;
    localparam int P_WF_B    = 1;
    localparam int P_WF_WKUP = 2;
    localparam int P_ACK     = 3;

    localparam int N_DONE    = 3;
    localparam int D_COPY    = 0;
    localparam int D_SHIFT   = 1;
    localparam int D_CALIB   = 2;

    typedef struct packed {
        logic recal;
        logic init;
        logic ack;
        logic sync;
        logic inits;
        logic shift;
        logic wf_wkup;
        logic wf_b;
        logic wf_a;
    } flags_t;

    function automatic logic [STATUS_W-1:0] pack_status(input flags_t f);
        logic [STATUS_W-1:0] w;
        w            = '0;
        w[B_WF_A]    = f.wf_a;
        w[B_WF_B]    = f.wf_b;
        w[B_WF_WKUP] = f.wf_wkup;
        w[B_SHIFT]   = f.shift;
        w[B_INITS]   = f.inits;
        w[B_SYNC]    = f.sync;
        w[B_ACK]     = f.ack;
        w[B_INIT]    = f.init;
        w[B_RECAL]   = f.recal;
        return w;
    endfunction

endpackage

// File: rtl/rtc_init_sync.sv
module rtc_init_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rtc_init_pulse_xfer.sv
module rtc_init_pulse_xfer #(
    parameter int N = 3
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [N-1:0] src_pulse,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [N-1:0] dst_pulse
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic tog;
        logic s1, s2, s3;

        always_ff @(posedge src_clk) begin
            if (src_rst) tog <= 1'b0;
            else if (src_pulse[g]) tog <= ~tog;
        end

        always_ff @(posedge dst_clk) begin
            if (dst_rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= tog;
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign dst_pulse[g] = s2 ^ s3;
    end
endmodule

// File: rtl/rtc_init_rtcside.sv
module rtc_init_rtcside
    import rtc_init_pkg::*;
(
    input  logic              rtc_clk,
    input  logic              rtc_rst,
    input  logic              init_req,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              en_wkup,
    output logic              cnt_stop,
    output logic [PERM_W-1:0] perm_q
);
    logic [3:0] s_in;
    logic [3:0] s_out;
    logic [PERM_W-1:0] perm_d;

    assign s_in = {init_req, en_wkup, en_b, en_a};

    rtc_init_sync #(.W(4)) u_sync (
        .clk (rtc_clk),
        .rst (rtc_rst),
        .d   (s_in),
        .q   (s_out)
    );

    assign cnt_stop = s_out[3];

    always_comb begin
        perm_d            = '0;
        perm_d[P_ACK]     = s_out[3];
        perm_d[P_WF_A]    = ~s_out[0] & ~s_out[3];
        perm_d[P_WF_B]    = ~s_out[1] & ~s_out[3];
        perm_d[P_WF_WKUP] = ~s_out[2] & ~s_out[3];
    end

    always_ff @(posedge rtc_clk) begin
        if (rtc_rst) perm_q <= '0;
        else         perm_q <= perm_d;
    end

    assert_stop_ack_R2: assert property (@(posedge rtc_clk) disable iff (rtc_rst)
        cnt_stop |=> perm_q[P_ACK]);
    assert_run_noack_R2: assert property (@(posedge rtc_clk) disable iff (rtc_rst)
        !cnt_stop |=> !perm_q[P_ACK]);
endmodule

// File: rtl/rtc_init_flags.sv
module rtc_init_flags
    import rtc_init_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int A_CTRL  = 0,
    parameter int A_SHIFT = 1,
    parameter int A_CALIB = 2,
    parameter int A_TIME  = 3,
    parameter int A_DATE  = 4,
    parameter int A_PRESC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              bypass,
    input  logic [PERM_W-1:0] perm_sync,
    input  logic              year_sync,
    input  logic [N_DONE-1:0] done_p,
    output flags_t            flags,
    output logic [2:0]        cal_load,
    output logic              calib_load,
    output logic              shift_load
);
    localparam int N_CAL = 3;
    localparam logic [ADDR_W-1:0] CAL_ADDR [N_CAL] = '{
        ADDR_W'(A_TIME), ADDR_W'(A_DATE), ADDR_W'(A_PRESC)};

    logic init_q, shift_q, sync_q, recal_q;
    logic init_n, shift_n, sync_n, recal_n;
    logic sel_ctrl, sel_shift, sel_calib;
    logic sync_hold, sync_clr;
    logic unused_wdata;

    assign unused_wdata = ^{wr_data[31:8], wr_data[6], wr_data[4:0]};

    assign sel_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
    assign sel_shift = wr_en && (wr_addr == ADDR_W'(A_SHIFT));
    assign sel_calib = wr_en && (wr_addr == ADDR_W'(A_CALIB));

    assign shift_load = sel_shift;
    assign calib_load = sel_calib && !recal_q;

    always_comb begin
        init_n  = sel_ctrl ? wr_data[B_INIT] : init_q;
        shift_n = sel_shift ? 1'b1 : (done_p[D_SHIFT] ? 1'b0 : shift_q);
        recal_n = calib_load ? 1'b1 : (done_p[D_CALIB] ? 1'b0 : recal_q);
        sync_hold = init_n | shift_n | bypass;
        sync_clr  = sel_ctrl && !wr_data[B_SYNC];
        if (sync_hold || sync_clr) sync_n = 1'b0;
        else if (done_p[D_COPY])   sync_n = 1'b1;
        else                       sync_n = sync_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q  <= 1'b0;
            shift_q <= 1'b0;
            sync_q  <= 1'b0;
            recal_q <= 1'b0;
        end else begin
            init_q  <= init_n;
            shift_q <= shift_n;
            sync_q  <= sync_n;
            recal_q <= recal_n;
        end
    end

    always_comb begin
        flags.init    = init_q;
        flags.ack     = init_q & perm_sync[P_ACK];
        flags.wf_a    = ~init_q & perm_sync[P_WF_A];
        flags.wf_b    = ~init_q & perm_sync[P_WF_B];
        flags.wf_wkup = ~init_q & perm_sync[P_WF_WKUP];
        flags.shift   = shift_q;
        flags.sync    = sync_q;
        flags.inits   = year_sync;
        flags.recal   = recal_q;
    end

    for (genvar g = 0; g < N_CAL; g++) begin : g_cal
        assign cal_load[g] = wr_en && (wr_addr == CAL_ADDR[g]) && flags.ack;
    end

    assert_shift_set_R5: assert property (@(posedge clk) disable iff (rst)
        sel_shift |=> shift_q);
    assert_shift_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_q) |-> $past(done_p[D_SHIFT]));
    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (init_q || shift_q) |-> !sync_q);
    assert_recal_set_R8: assert property (@(posedge clk) disable iff (rst)
        calib_load |=> recal_q);
    assert_recal_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(recal_q) |-> $past(done_p[D_CALIB]));
endmodule

// File: rtl/rtc_init_ctrl.sv
module rtc_init_ctrl
    import rtc_init_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int A_CTRL  = 0,
    parameter int A_SHIFT = 1,
    parameter int A_CALIB = 2,
    parameter int A_TIME  = 3,
    parameter int A_DATE  = 4,
    parameter int A_PRESC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rtc_clk,
    input  logic              rtc_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              alarm_a_en,
    input  logic              alarm_b_en,
    input  logic              wkup_en,
    input  logic              shadow_bypass,
    input  logic              year_nonzero,
    input  logic              copy_done,
    input  logic              shift_done,
    input  logic              calib_done,
    output logic [31:0]       status,
    output logic              init_ack,
    output logic              cnt_stop,
    output logic              wr_ok_alarm_a,
    output logic              wr_ok_alarm_b,
    output logic              wr_ok_wkup,
    output logic [2:0]        cal_load,
    output logic              calib_load,
    output logic              shift_load
);
    flags_t              flags;
    logic [PERM_W-1:0]   perm_rtc;
    logic [PERM_W-1:0]   perm_bus;
    logic [N_DONE-1:0]   done_rtc;
    logic [N_DONE-1:0]   done_bus;
    logic                year_bus;

    assign done_rtc[D_COPY]  = copy_done;
    assign done_rtc[D_SHIFT] = shift_done;
    assign done_rtc[D_CALIB] = calib_done;

    rtc_init_rtcside u_rtc (
        .rtc_clk  (rtc_clk),
        .rtc_rst  (rtc_rst),
        .init_req (flags.init),
        .en_a     (alarm_a_en),
        .en_b     (alarm_b_en),
        .en_wkup  (wkup_en),
        .cnt_stop (cnt_stop),
        .perm_q   (perm_rtc)
    );

    rtc_init_sync #(.W(PERM_W + 1)) u_back (
        .clk (clk),
        .rst (rst),
        .d   ({year_nonzero, perm_rtc}),
        .q   ({year_bus, perm_bus})
    );

    rtc_init_pulse_xfer #(.N(N_DONE)) u_done (
        .src_clk   (rtc_clk),
        .src_rst   (rtc_rst),
        .src_pulse (done_rtc),
        .dst_clk   (clk),
        .dst_rst   (rst),
        .dst_pulse (done_bus)
    );

    rtc_init_flags #(
        .ADDR_W (ADDR_W), .A_CTRL (A_CTRL), .A_SHIFT (A_SHIFT),
        .A_CALIB (A_CALIB), .A_TIME (A_TIME), .A_DATE (A_DATE),
        .A_PRESC (A_PRESC)
    ) u_flags (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .bypass     (shadow_bypass),
        .perm_sync  (perm_bus),
        .year_sync  (year_bus),
        .done_p     (done_bus),
        .flags      (flags),
        .cal_load   (cal_load),
        .calib_load (calib_load),
        .shift_load (shift_load)
    );

    assign status        = pack_status(flags);
    assign init_ack      = flags.ack;
    assign wr_ok_alarm_a = flags.wf_a;
    assign wr_ok_alarm_b = flags.wf_b;
    assign wr_ok_wkup    = flags.wf_wkup;

    assert_ack_needs_init_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(init_ack) |-> $past(status[B_INIT]));
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (status[15:8] == 8'h00) && (status[31:17] == 15'h0000));
endmodule

// File: tb/rtc_init_ctrl_test.sv
module rtc_init_ctrl_test;
    logic clk = 1'b0, rtc_clk = 1'b0;
    logic rst = 1'b1, rtc_rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic alarm_a_en = 1'b1, alarm_b_en = 1'b1, wkup_en = 1'b1;
    logic shadow_bypass = 1'b0, year_nonzero = 1'b0;
    logic copy_done = 1'b0, shift_done = 1'b0, calib_done = 1'b0;
    logic [31:0] status;
    logic init_ack, cnt_stop, wr_ok_alarm_a, wr_ok_alarm_b, wr_ok_wkup;
    logic [2:0] cal_load;
    logic calib_load, shift_load;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [2:0] cap_cal;
    logic cap_calib, cap_shift;

    always #2.5 clk = ~clk;
    always #15  rtc_clk = ~rtc_clk;

    rtc_init_ctrl uut (
        .clk(clk), .rst(rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_a_en(alarm_a_en), .alarm_b_en(alarm_b_en), .wkup_en(wkup_en),
        .shadow_bypass(shadow_bypass), .year_nonzero(year_nonzero),
        .copy_done(copy_done), .shift_done(shift_done), .calib_done(calib_done),
        .status(status), .init_ack(init_ack), .cnt_stop(cnt_stop),
        .wr_ok_alarm_a(wr_ok_alarm_a), .wr_ok_alarm_b(wr_ok_alarm_b),
        .wr_ok_wkup(wr_ok_wkup), .cal_load(cal_load), .calib_load(calib_load),
        .shift_load(shift_load)
    );

    function automatic logic [31:0] expect_word(input logic wa, wb, ww, sh,
        inits, sy, ack, ini, rc);
        return (32'(wa) << 0) | (32'(wb) << 1) | (32'(ww) << 2) | (32'(sh) << 3)
             | (32'(inits) << 4) | (32'(sy) << 5) | (32'(ack) << 6)
             | (32'(ini) << 7) | (32'(rc) << 16);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        cap_cal = cal_load; cap_calib = calib_load; cap_shift = shift_load;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge rtc_clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic rtc_pulse(input int which);
        @(negedge rtc_clk);
        if (which == 0) copy_done = 1'b1;
        else if (which == 1) shift_done = 1'b1;
        else calib_done = 1'b1;
        @(negedge rtc_clk);
        copy_done = 1'b0; shift_done = 1'b0; calib_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge rtc_clk);
        @(negedge clk); rst = 1'b0;
        @(negedge rtc_clk); rtc_rst = 1'b0;
        repeat (2) @(negedge clk);
        // R9: reset state
        check("R9 reset status", status, 32'h0);
        check("R9 reset cnt_stop", {31'b0, cnt_stop}, 32'h0);

        // R3 R4 R2: sweep enables x INIT
        for (int k = 0; k < 16; k++) begin
            logic i, ea, eb, ew;
            {i, ew, eb, ea} = 4'(k);
            alarm_a_en = ea; alarm_b_en = eb; wkup_en = ew;
            bus_write(4'd0, 32'(i) << 7);
            settle();
            check("R3 R4 R2 sweep status", status,
                expect_word(~ea & ~i, ~eb & ~i, ~ew & ~i, 0, 0, 0, i, i, 0));
            check("R3 alarm ports", {30'b0, wr_ok_alarm_b, wr_ok_alarm_a},
                {30'b0, ~eb & ~i, ~ea & ~i});
            check("R4 wakeup port", {31'b0, wr_ok_wkup}, {31'b0, ~ew & ~i});
        end
        alarm_a_en = 1'b1; alarm_b_en = 1'b1; wkup_en = 1'b1;
        bus_write(4'd0, 32'h0);
        settle();

        // R1: counter stop timing
        bus_write(4'd0, 32'h80);
        check("R1 init readback", {31'b0, status[7]}, 32'h1);
        check("R1 cnt_stop not early", {31'b0, cnt_stop}, 32'h0);
        // R2: calendar write before acknowledge ignored
        bus_write(4'd3, 32'h0);
        check("R2 cal_load before ack", {29'b0, cap_cal}, 32'h0);
        settle();
        check("R1 cnt_stop set", {31'b0, cnt_stop}, 32'h1);
        check("R2 init_ack set", {31'b0, init_ack}, 32'h1);
        for (int a = 3; a <= 5; a++) begin
            bus_write(4'(a), 32'h0);
            check("R2 cal_load in init", {29'b0, cap_cal}, 32'(1) << (a - 3));
        end
        bus_write(4'd0, 32'h0);
        check("R2 ack drops at once", {31'b0, init_ack}, 32'h0);
        settle();
        check("R1 cnt_stop cleared", {31'b0, cnt_stop}, 32'h0);
        for (int a = 3; a <= 5; a++) begin
            bus_write(4'(a), 32'h0);
            check("R2 cal_load outside init", {29'b0, cap_cal}, 32'h0);
        end

        // R5: shift pending, ctrl bit3 writes no effect
        bus_write(4'd0, 32'h08);
        check("R5 ctrl bit3 ignored", {31'b0, status[3]}, 32'h0);
        bus_write(4'd0, 32'h80);
        bus_write(4'd1, 32'h0);
        check("R5 shift_load pulse", {31'b0, cap_shift}, 32'h1);
        check("R5 shift pending set", {31'b0, status[3]}, 32'h1);
        bus_write(4'd0, 32'h00);
        settle();
        check("R5 pending survives init clear", {31'b0, status[3]}, 32'h1);
        rtc_pulse(1);
        settle();
        check("R5 pending cleared by done", {31'b0, status[3]}, 32'h0);

        // R6: sweep hold conditions
        for (int k = 0; k < 8; k++) begin
            logic i, s, b;
            {i, s, b} = 3'(k);
            shadow_bypass = b;
            bus_write(4'd0, (32'(i) << 7) | 32'h20);
            if (s) bus_write(4'd1, 32'h0);
            settle();
            rtc_pulse(0);
            settle();
            check("R6 sync under hold sweep", {31'b0, status[5]}, {31'b0, ~(i | s | b)});
            if (s) begin
                rtc_pulse(1);
                settle();
                check("R5 pending cleared in sweep", {31'b0, status[3]}, 32'h0);
            end
            shadow_bypass = 1'b0;
            bus_write(4'd0, 32'h0);
            check("R6 software clear", {31'b0, status[5]}, 32'h0);
            settle();
        end

        // R6: same-edge clear by shift write, and write-1 no effect
        rtc_pulse(0);
        settle();
        check("R6 sync set", {31'b0, status[5]}, 32'h1);
        bus_write(4'd0, 32'h20);
        check("R6 write one no effect", {31'b0, status[5]}, 32'h1);
        bus_write(4'd1, 32'h0);
        check("R6 same edge shift", {30'b0, status[5], status[3]}, 32'h1);
        rtc_pulse(1);
        settle();
        rtc_pulse(0);
        settle();
        bus_write(4'd0, 32'hA0);
        check("R6 same edge init", {30'b0, status[7], status[5]}, 32'h2);
        bus_write(4'd0, 32'h0);
        settle();

        // R7: init status follows year
        year_nonzero = 1'b1;
        settle();
        check("R7 inits high", {31'b0, status[4]}, 32'h1);
        year_nonzero = 1'b0;
        settle();
        check("R7 inits low", {31'b0, status[4]}, 32'h0);

        // R8: recalibration
        bus_write(4'd2, 32'h0);
        check("R8 first calib accepted", {31'b0, cap_calib}, 32'h1);
        check("R8 pending set", {31'b0, status[16]}, 32'h1);
        bus_write(4'd2, 32'h0);
        check("R8 blocked while pending", {31'b0, cap_calib}, 32'h0);
        rtc_pulse(2);
        settle();
        check("R8 pending cleared", {31'b0, status[16]}, 32'h0);
        bus_write(4'd2, 32'h0);
        check("R8 accepted again", {31'b0, cap_calib}, 32'h1);
        rtc_pulse(2);
        settle();
        check("R9 final status", status, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule